// File: doc/BRIEF.md
# SHA-1 Compression Engine with Byte Parity Prediction

This block runs the SHA-1 compression function on one 512-bit message block at a time. Control software pads the message beforehand. It then writes the block as sixteen 32-bit words, most significant word first, and pulses a start command. The engine keeps the 160-bit chaining state from one block to the next, so a multi-block message is hashed by loading and starting each block in turn. After the last block the chaining state is the digest. An explicit initialise command reloads the standard starting constants before a new message.

Each round takes two clock cycles. The first cycle forms `e + K + W`. The second cycle adds `rotl5(a) + f(b,c,d)` and then the partial sum from the first cycle. Two shared 32-bit adders do every addition in the engine, so no cycle has more than two additions. A block completes in 163 cycles: 160 round cycles and 3 cycles that add the working variables back into the chaining state. The message schedule is built on the fly in a sixteen-word circular buffer.

Every 32-bit word in the dataflow carries one parity bit per byte. Adders, XORs and rotations predict the parity of their results from the operand parities. The adders also use an independently computed carry vector for their prediction. Every stored word is checked against its parity on every cycle, and a mismatch sets a sticky error flag.

Top module: `sha1_par_engine`

## Requirements
- R1: After reset, busy, done and err are 0 and digest equals 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0, with the first word in digest[159:128].
- R2: While idle, each cycle with in_valid high stores in_word and in_par into the next word slot. Slots fill in block order, word 0 being bits 511:480 of the block. The slot counter returns to word 0 on reset and on every accepted start.
- R3: A start while idle makes busy high from the next cycle. done is high for exactly one cycle, following the 163rd rising edge after the edge that sampled start. busy is low while done is high.
- R4: When done is high, digest equals the SHA-1 compression of the previous chaining state with the loaded block. Consecutive blocks started without init therefore chain.
- R5: init while idle reloads the five starting constants into the chaining state and leaves err unchanged.
- R6: start, init and in_valid are ignored while busy. The running block's result and timing are unaffected.
- R7: digest_par[4k+j] is the XOR of the eight bits of byte j (byte 0 least significant) of digest word k, where word 0 is the least significant word. This holds whenever no parity fault has occurred.
- R8: err goes high when any stored word disagrees with its parity bits, including a word loaded with wrong in_par. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Reload starting chaining constants (idle only) |
| start | input | 1 | Begin compressing the loaded block (idle only) |
| in_valid | input | 1 | Write in_word into the next word slot (idle only) |
| in_word | input | 32 | Message word |
| in_par | input | 4 | Byte parity of in_word, bit j for byte j |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse when the digest has been updated |
| err | output | 1 | Sticky parity fault flag |
| digest | output | 160 | Chaining state, first word in the top bits |
| digest_par | output | 20 | Byte parity of digest |

## Verification
On every cycle the assertions check four things: the one-cycle shape of done, that busy follows an accepted start, that err is sticky, and that digest_par matches the digest bytes whenever no fault has been flagged. Only the bench's scenarios can show three other behaviours. The first is that the digest equals a SHA-1 computed independently, for a known answer, for chained blocks and for a sweep of random blocks. The second is the exact 163-cycle latency. The third is that commands arriving mid-block are ignored. The bench also covers err being raised by a word loaded with bad parity.

// File: rtl/sha1_par_engine.sv
module sha1_par_engine (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         start,
  input  logic         in_valid,
  input  logic [31:0]  in_word,
  input  logic [3:0]   in_par,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [159:0] digest,
  output logic [19:0]  digest_par
);
  localparam logic [31:0] IV [5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
  localparam int LAST = 79;

  typedef enum logic [1:0] {S_IDLE, S_RND, S_FIN} st_t;

  function automatic logic [3:0] bpar(input logic [31:0] x);
    for (int k = 0; k < 4; k++) bpar[k] = ^x[8*k +: 8];
  endfunction

  function automatic logic [35:0] addp(input logic [31:0] x, input logic [3:0] px,
                                       input logic [31:0] y, input logic [3:0] py);
    logic [32:0] cy;
    logic [3:0]  p;
    cy[0] = 1'b0;
    for (int i = 0; i < 32; i++) cy[i+1] = (x[i] & y[i]) | ((x[i] ^ y[i]) & cy[i]);
    for (int k = 0; k < 4; k++) p[k] = px[k] ^ py[k] ^ (^cy[8*k +: 8]);
    return {p, x + y};
  endfunction

  function automatic logic [3:0] rolp(input logic [31:0] x, input logic [3:0] px, input int r);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      p[k] = px[k];
      for (int j = 0; j < r; j++)
        p[k] = p[k] ^ x[8*k + 7 - j] ^ x[(8*k + 31 - j) % 32];
    end
    return p;
  endfunction

  st_t         st;
  logic [6:0]  t;
  logic        ph;
  logic [1:0]  fc;
  logic [3:0]  wcnt;
  logic [31:0] wd [16];
  logic [3:0]  wp [16];
  logic [31:0] a, b, c, d, e, tmp;
  logic [3:0]  pa, pb, pc, pd, pe, ptmp;
  logic [31:0] hv [5];
  logic [3:0]  hp [5];

  logic [31:0] wx, wt, f, kc, x1, y1, x2, y2;
  logic [3:0]  pwx, pwt, pf, px1, py1, px2, py2, pc30;
  logic [35:0] s1, s2;
  logic        xor_rnd, bad;
  logic [3:0]  p6;

  assign busy       = (st != S_IDLE);
  assign digest     = {hv[0], hv[1], hv[2], hv[3], hv[4]};
  assign digest_par = {hp[0], hp[1], hp[2], hp[3], hp[4]};

  assign wx  = wd[t[3:0] + 4'd13] ^ wd[t[3:0] + 4'd8] ^ wd[t[3:0] + 4'd2] ^ wd[t[3:0]];
  assign pwx = wp[t[3:0] + 4'd13] ^ wp[t[3:0] + 4'd8] ^ wp[t[3:0] + 4'd2] ^ wp[t[3:0]];
  assign wt  = (t < 7'd16) ? wd[t[3:0]] : {wx[30:0], wx[31]};
  assign pwt = (t < 7'd16) ? wp[t[3:0]] : rolp(wx, pwx, 1);

  assign xor_rnd = (t >= 7'd20 && t < 7'd40) || t >= 7'd60;
  assign kc = (t < 7'd20) ? 32'h5A827999 : (t < 7'd40) ? 32'h6ED9EBA1 :
              (t < 7'd60) ? 32'h8F1BBCDC : 32'hCA62C1D6;
  assign f  = (t < 7'd20) ? ((b & c) | (~b & d)) :
              xor_rnd     ? (b ^ c ^ d) : ((b & c) | (b & d) | (c & d));
  assign pf = xor_rnd ? (pb ^ pc ^ pd) : bpar(f);

  assign p6   = rolp(b, pb, 6);
  assign pc30 = {p6[0], p6[3:1]};

  always_comb begin
    x1 = e; px1 = pe; y1 = kc; py1 = bpar(kc);
    x2 = s1[31:0]; px2 = s1[35:32]; y2 = wt; py2 = pwt;
    if (st == S_RND && ph) begin
      x1 = {a[26:0], a[31:27]}; px1 = rolp(a, pa, 5);
      y1 = f; py1 = pf;
      y2 = tmp; py2 = ptmp;
    end else if (st == S_FIN) begin
      x1 = hv[{fc, 1'b0}]; px1 = hp[{fc, 1'b0}];
      y1 = (fc == 2'd0) ? a : (fc == 2'd1) ? c : e;
      py1 = (fc == 2'd0) ? pa : (fc == 2'd1) ? pc : pe;
      x2 = (fc == 2'd2) ? 32'd0 : hv[{fc, 1'b1}];
      px2 = (fc == 2'd2) ? 4'd0 : hp[{fc, 1'b1}];
      y2 = (fc == 2'd0) ? b : (fc == 2'd1) ? d : 32'd0;
      py2 = (fc == 2'd0) ? pb : (fc == 2'd1) ? pd : 4'd0;
    end
  end

  assign s1 = addp(x1, px1, y1, py1);
  assign s2 = addp(x2, px2, y2, py2);

  always_comb begin
    bad = (bpar(a) != pa) || (bpar(b) != pb) || (bpar(c) != pc) ||
          (bpar(d) != pd) || (bpar(e) != pe) || (bpar(tmp) != ptmp);
    for (int i = 0; i < 5; i++)  bad = bad || (bpar(hv[i]) != hp[i]);
    for (int i = 0; i < 16; i++) bad = bad || (bpar(wd[i]) != wp[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; t <= '0; ph <= 1'b0; fc <= '0; wcnt <= '0;
      done <= 1'b0; err <= 1'b0;
      {a, b, c, d, e, tmp} <= '0;
      {pa, pb, pc, pd, pe, ptmp} <= '0;
      for (int i = 0; i < 16; i++) begin wd[i] <= '0; wp[i] <= '0; end
      for (int i = 0; i < 5; i++) begin hv[i] <= IV[i]; hp[i] <= bpar(IV[i]); end
    end else begin
      done <= 1'b0;
      err  <= err | bad;
      case (st)
        S_IDLE: begin
          if (in_valid) begin
            wd[wcnt] <= in_word; wp[wcnt] <= in_par; wcnt <= wcnt + 4'd1;
          end
          if (init)
            for (int i = 0; i < 5; i++) begin hv[i] <= IV[i]; hp[i] <= bpar(IV[i]); end
          if (start) begin
            a <= hv[0]; b <= hv[1]; c <= hv[2]; d <= hv[3]; e <= hv[4];
            pa <= hp[0]; pb <= hp[1]; pc <= hp[2]; pd <= hp[3]; pe <= hp[4];
            t <= '0; ph <= 1'b0; wcnt <= '0; st <= S_RND;
          end
        end
        S_RND: begin
          if (!ph) begin
            tmp <= s2[31:0]; ptmp <= s2[35:32];
            if (t >= 7'd16) begin wd[t[3:0]] <= wt; wp[t[3:0]] <= pwt; end
            ph <= 1'b1;
          end else begin
            e <= d; pe <= pd; d <= c; pd <= pc;
            c <= {b[1:0], b[31:2]}; pc <= pc30;
            b <= a; pb <= pa;
            a <= s2[31:0]; pa <= s2[35:32];
            ph <= 1'b0;
            if (t == 7'(LAST)) begin st <= S_FIN; fc <= '0; end
            else t <= t + 7'd1;
          end
        end
        default: begin
          hv[{fc, 1'b0}] <= s1[31:0]; hp[{fc, 1'b0}] <= s1[35:32];
          if (fc != 2'd2) begin
            hv[{fc, 1'b1}] <= s2[31:0]; hp[{fc, 1'b1}] <= s2[35:32];
            fc <= fc + 2'd1;
          end else begin
            st <= S_IDLE; done <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sha1_par_engine_chk.sv
module sha1_par_engine_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [159:0] digest,
  input logic [19:0]  digest_par
);
  function automatic logic [19:0] dpar(input logic [159:0] x);
    for (int k = 0; k < 20; k++) dpar[k] = ^x[8*k +: 8];
  endfunction

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> (busy || done));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  p_digest_par_r7: assert property (@(posedge clk) disable iff (!rst_n)
                                    (!busy && !err) |-> (digest_par == dpar(digest)));
endmodule

bind sha1_par_engine sha1_par_engine_chk u_chk (.*);

// File: tb/sha1_par_engine_bench.sv
module sha1_par_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [3:0] in_par = '0;
  logic busy, done, err;
  logic [159:0] digest;
  logic [19:0] digest_par;
  int checks = 0, errors = 0, cyc = 0;

  localparam logic [159:0] IVW = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  sha1_par_engine u_sha1_par_engine (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [3:0] bp(input logic [31:0] x);
    for (int k = 0; k < 4; k++) bp[k] = ^x[8*k +: 8];
  endfunction

  function automatic logic [19:0] dp(input logic [159:0] x);
    for (int k = 0; k < 20; k++) dp[k] = ^x[8*k +: 8];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_blk(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] va, vb, vc, vd, ve, fn, kk, tt;
    for (int i = 0; i < 16; i++) w[i] = m[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {va, vb, vc, vd, ve} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin fn = (vb & vc) | (~vb & vd); kk = 32'h5A827999; end
      else if (i < 40) begin fn = vb ^ vc ^ vd; kk = 32'h6ED9EBA1; end
      else if (i < 60) begin fn = (vb & vc) | (vb & vd) | (vc & vd); kk = 32'h8F1BBCDC; end
      else             begin fn = vb ^ vc ^ vd; kk = 32'hCA62C1D6; end
      tt = rl(va, 5) + fn + ve + kk + w[i];
      ve = vd; vd = vc; vc = rl(vb, 30); vb = va; va = tt;
    end
    return {h[159:128] + va, h[127:96] + vb, h[95:64] + vc, h[63:32] + vd, h[31:0] + ve};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [511:0] m, input int bad_idx);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word = m[511 - 32*i -: 32];
      in_par = bp(in_word) ^ ((i == bad_idx) ? 4'b0001 : 4'b0000);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
  endtask

  task automatic run(input logic [159:0] exp, input bit disturb, input bit chk_par, input string tag);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", {159'd0, busy}, 160'd1);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (disturb && n == 40) begin
        start = 1'b1; init = 1'b1; in_valid = 1'b1; in_word = 32'hDEADBEEF; in_par = bp(32'hDEADBEEF);
      end else if (disturb && n == 41) begin
        start = 1'b0; init = 1'b0; in_valid = 1'b0;
      end
    end
    chk(n == 163, {tag, " R3 latency"}, 160'(n), 160'd163);
    chk(busy == 1'b0, {tag, " R3 busy low with done"}, {159'd0, busy}, 160'd0);
    chk(digest == exp, {tag, " R4 digest"}, digest, exp);
    if (chk_par) chk(digest_par == dp(digest), {tag, " R7 digest parity"}, {140'd0, digest_par}, {140'd0, dp(digest)});
    @(negedge clk);
    chk(done == 1'b0, {tag, " R3 done one cycle"}, {159'd0, done}, 160'd0);
  endtask

  initial begin
    logic [511:0] abc, m, m2;
    logic [159:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(digest == IVW, "R1 reset digest", digest, IVW);
    chk({busy, done, err} == 3'b000, "R1 reset flags", {157'd0, busy, done, err}, 160'd0);
    chk(digest_par == dp(IVW), "R7 reset parity", {140'd0, digest_par}, {140'd0, dp(IVW)});

    abc = {32'h61626380, 416'd0, 64'h18};
    load(abc, -1);
    run(160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, 1'b0, 1'b1, "R2 known answer");
    chk(digest == ref_blk(IVW, abc), "R4 model agrees", digest, ref_blk(IVW, abc));

    h = digest;
    m = {16{32'h01234567}};
    load(m, -1);
    run(ref_blk(h, m), 1'b0, 1'b1, "chain");

    pulse_init();
    chk(digest == IVW, "R5 init reload", digest, IVW);
    chk(err == 1'b0, "R5 err unchanged", {159'd0, err}, 160'd0);

    m2 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    load(m2, -1);
    run(ref_blk(IVW, m2), 1'b1, 1'b1, "R6 ignore while busy");

    for (int r = 0; r < 20; r++) begin
      h = digest;
      if (r % 4 == 0) begin pulse_init(); h = IVW; end
      for (int i = 0; i < 16; i++) m[511 - 32*i -: 32] = (r == 1) ? 32'hFFFFFFFF : (r == 2) ? 32'd0 : $urandom;
      load(m, -1);
      run(ref_blk(h, m), 1'b0, 1'b1, "sweep");
    end
    chk(err == 1'b0, "R8 no fault in clean runs", {159'd0, err}, 160'd0);

    h = digest;
    load(m2, 5);
    @(negedge clk);
    chk(err == 1'b1, "R8 bad input parity flagged", {159'd0, err}, 160'd1);
    run(ref_blk(h, m2), 1'b0, 1'b0, "R8 faulty word");
    chk(err == 1'b1, "R8 err sticky", {159'd0, err}, 160'd1);
    pulse_init();
    chk(err == 1'b1, "R8 init keeps err", {159'd0, err}, 160'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R8 reset clears err", {159'd0, err}, 160'd0);
    chk(digest == IVW, "R1 digest after second reset", digest, IVW);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule